// File: doc/BRIEF.md
# Stimulus Port Trace FIFO

This block turns software writes into a stream of trace words. A 32-bit write to any one of 32 stimulus port addresses is pushed into a four-entry FIFO, tagged with the number of the port it was written to. A write is accepted only when a master trace enable is set, the per-port enable bit for that port is set, and the FIFO has room. A write that finds the FIFO full is dropped, and a sticky overflow flag records it. Software polls a port address to learn whether the FIFO has room before it writes.

The FIFO drains onto a valid/ready output stream. A word moves on every clock edge where `trc_valid` and `trc_ready` are both high. While `trc_ready` is low, the head word, its port tag and `trc_valid` hold steady. The consumer may hold `trc_ready` high at any time. The stream also carries a 7-bit source ID, taken from a control register field. An integration test mode lets software drive `trc_valid` directly and read back the live level of `trc_ready`. While that mode is on, the FIFO does not drain.

Register map (byte offsets; `addr[1:0]` ignored). Stimulus port N sits at 4*N, for N from 0 to 31. Port enable mask at 0x400. Control at 0x404. Integration drive at 0x408. Integration sample at 0x40C. Integration mode at 0x410. All other offsets read as zero.

Top module: `stim_trace_fifo`

## Requirements
- R1: A write to offset 4*N (N = 0..31) is pushed when all three hold: control bit 0 (master enable) is 1, bit N of the mask register at 0x400 is 1, and the FIFO is not full. The word appears at the head, with `trc_port` = N and `trc_valid` high, from the clock edge that accepts it.
- R2: A port write whose mask bit is 0 is dropped, and the FIFO is unchanged.
- R3: While control bit 0 is 0, every port write is dropped.
- R4: A read (`rd_en`) of any offset 4*N returns bit 0 = 1 when the FIFO has room and 0 when it is full, and bit 1 = the overflow flag. All other bits are 0. Every read result appears on `rdata` from the edge that samples `rd_en`, and holds until the next read.
- R5: A port write that passes the R1 enables while the FIFO (4 entries) is full is dropped and sets the overflow flag. The flag stays set until a status read clears it. That read still returns 1 in bit 1. An overflow in the same cycle as the read wins over the clear.
- R6: With integration mode off, `trc_valid` is high exactly when the FIFO is not empty. Words leave in write order, one on each edge where valid and ready are both high. While ready is low, `trc_data` and `trc_port` are stable.
- R7: `busy` is high whenever the FIFO holds at least one entry.
- R8: `trc_src_id` equals control bits [14:8]. A read of the control register returns master enable in bit 0, the ID in bits [14:8] and `busy` in bit 31.
- R9: When bit 0 at 0x410 is 1, `trc_valid` equals bit 0 of the register at 0x408 and the FIFO does not drain. When it is 0, R6 applies.
- R10: A read of 0x40C returns the level of `trc_ready` in the sampling cycle in bit 0.
- R11: After reset the FIFO is empty, `trc_valid` and `busy` are 0, and all registers read 0. A status read returns 1.
- R12: The mask, integration drive and integration mode registers read back what was last written. Mode and drive read back in bit 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| trc_valid | output | 1 | Output word valid |
| trc_ready | input | 1 | Output consumer ready |
| trc_data | output | 32 | Head word data |
| trc_port | output | 5 | Head word port number |
| trc_src_id | output | 7 | Trace source ID |
| busy | output | 1 | FIFO holds entries |

## Verification
Every result in this block is due exactly one edge after its stimulus. An accepted write shows on `trc_valid`/`trc_data`/`busy` after the edge that samples `wr_en`. `rdata` holds the read result after the edge that samples `rd_en`. A pop advances the head after the edge where valid and ready are both high. The bench drives every strobe on a falling edge, drops it on the next falling edge, and samples outputs at that second falling edge, when exactly one rising edge has passed. It sweeps all 32 port addresses, both for writes with alternating mask bits and for status reads, and fills the FIFO past its depth to check ordering, dropping and the sticky flag.

// File: rtl/stim_trace_pkg.sv
package stim_trace_pkg;
  localparam int unsigned OFF_MASK    = 32'h400;
  localparam int unsigned OFF_CTRL    = 32'h404;
  localparam int unsigned OFF_IDRIVE  = 32'h408;
  localparam int unsigned OFF_ISAMPLE = 32'h40C;
  localparam int unsigned OFF_IMODE   = 32'h410;
  localparam int unsigned CTRL_ID_LSB = 8;
  localparam int unsigned CTRL_BUSY_BIT = 31;
endpackage

// File: rtl/stf_fifo.sv
module stf_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R5: nothing is written over a full FIFO
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R6: no pop from an empty FIFO
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  // R6: the head holds while nothing is popped
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(dout));
endmodule

// File: rtl/stf_ctrl.sv
module stf_ctrl
  import stim_trace_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NPORTS = 32,
  parameter int ID_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              fifo_full,
  input  logic              busy,
  input  logic              trc_ready,
  output logic              push,
  output logic [$clog2(NPORTS)-1:0] push_port,
  output logic [ID_W-1:0]   src_id,
  output logic              integ_mode,
  output logic              integ_drive
);
  localparam int PW     = $clog2(NPORTS);
  localparam int SPAN_W = PW + 2;
  localparam int WA_W   = ADDR_W - 2;

  logic [NPORTS-1:0] mask;
  logic              master;
  logic              overflow;
  logic              port_hit, port_wr, gated, status_rd;
  logic [WA_W-1:0]   waddr;

  assign waddr     = addr[ADDR_W-1:2];
  assign port_hit  = (addr[ADDR_W-1:SPAN_W] == '0);
  assign push_port = addr[SPAN_W-1:2];
  assign port_wr   = wr_en && port_hit;
  assign gated     = port_wr && master && mask[push_port];
  assign push      = gated && !fifo_full;
  assign status_rd = rd_en && port_hit;

  function automatic logic at(input logic [WA_W-1:0] a, input int unsigned off);
    return a == WA_W'(off >> 2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask        <= '0;
      master      <= 1'b0;
      src_id      <= '0;
      integ_mode  <= 1'b0;
      integ_drive <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      if (wr_en && at(waddr, OFF_MASK)) mask <= wdata[NPORTS-1:0];
      if (wr_en && at(waddr, OFF_CTRL)) begin
        master <= wdata[0];
        src_id <= wdata[CTRL_ID_LSB +: ID_W];
      end
      if (wr_en && at(waddr, OFF_IDRIVE)) integ_drive <= wdata[0];
      if (wr_en && at(waddr, OFF_IMODE))  integ_mode  <= wdata[0];
      if (gated && fifo_full) overflow <= 1'b1;
      else if (status_rd)     overflow <= 1'b0;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (port_hit) begin
      rd_mux[0] = !fifo_full;
      rd_mux[1] = overflow;
    end else if (at(waddr, OFF_MASK)) begin
      rd_mux[NPORTS-1:0] = mask;
    end else if (at(waddr, OFF_CTRL)) begin
      rd_mux[0] = master;
      rd_mux[CTRL_ID_LSB +: ID_W] = src_id;
      rd_mux[CTRL_BUSY_BIT] = busy;
    end else if (at(waddr, OFF_IDRIVE)) begin
      rd_mux[0] = integ_drive;
    end else if (at(waddr, OFF_ISAMPLE)) begin
      rd_mux[0] = trc_ready;
    end else if (at(waddr, OFF_IMODE)) begin
      rd_mux[0] = integ_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: a masked port never pushes
  p_mask_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !mask[push_port]) |-> !push);
  // R3: nothing is pushed while the master enable is off
  p_master_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !push);
  // R5: the overflow flag only clears through a status read
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !status_rd) |=> overflow);
endmodule

// File: rtl/stim_trace_fifo.sv
module stim_trace_fifo #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NPORTS = 32,
  parameter int ID_W   = 7,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      trc_valid,
  input  logic                      trc_ready,
  output logic [DATA_W-1:0]         trc_data,
  output logic [$clog2(NPORTS)-1:0] trc_port,
  output logic [ID_W-1:0]           trc_src_id,
  output logic                      busy
);
  localparam int PW = $clog2(NPORTS);
  localparam int EW = DATA_W + PW;

  logic          push, pop, full, empty, integ_mode, integ_drive;
  logic [PW-1:0] push_port;
  logic [EW-1:0] head;

  stf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(NPORTS), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fifo_full(full), .busy(busy),
    .trc_ready(trc_ready), .push(push), .push_port(push_port),
    .src_id(trc_src_id), .integ_mode(integ_mode), .integ_drive(integ_drive)
  );

  stf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din({push_port, wdata}),
    .pop(pop), .dout(head), .full(full), .empty(empty)
  );

  assign busy      = !empty;
  assign trc_valid = integ_mode ? integ_drive : !empty;
  assign pop       = !integ_mode && !empty && trc_ready;
  assign trc_data  = head[DATA_W-1:0];
  assign trc_port  = head[EW-1:DATA_W];

  // R6: an offered word stays offered until taken
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!integ_mode && trc_valid && !trc_ready) |=> trc_valid);
  // R7: busy only rises on an accepted write
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(push));
  // R9: integration mode never drains the FIFO
  p_integ_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_mode && busy) |=> busy);
endmodule

// File: tb/stim_trace_fifo_test.sv
module stim_trace_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, trc_ready = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, trc_data;
  logic        trc_valid, busy;
  logic [4:0]  trc_port;
  logic [6:0]  trc_src_id;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  stim_trace_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trc_valid(trc_valid), .trc_ready(trc_ready),
    .trc_data(trc_data), .trc_port(trc_port), .trc_src_id(trc_src_id), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pop1();
    @(negedge clk); trc_ready = 1'b1;
    @(negedge clk); trc_ready = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int n);
    return 32'h9E37_0000 ^ (32'(n) * 32'h0101_0203);
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] msk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'b0, trc_valid}, 0);
    check("R11 busy", {31'b0, busy}, 0);
    rd(12'h400, r); check("R11 mask", r, 0);
    rd(12'h404, r); check("R11 ctrl", r, 0);
    rd(12'h410, r); check("R11 mode", r, 0);
    rd(12'h000, r); check("R11 status", r, 32'h1);

    // R3 master off: enabled port write dropped
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h014, 32'h1234_5678);
    check("R3 dropped", {31'b0, busy}, 0);

    // R8 source id and control readback
    wr(12'h404, (32'h55 << 8) | 32'h1);
    check("R8 src id", {25'b0, trc_src_id}, 32'h55);
    rd(12'h404, r); check("R8 ctrl read", r, 32'h0000_5501);

    // R1/R2 sweep all ports with alternating mask
    msk = 32'hA5C3_3C5A;
    wr(12'h400, msk);
    rd(12'h400, r); check("R12 mask readback", r, msk);
    for (int n = 0; n < 32; n++) begin
      wr(12'(4 * n), pat(n));
      if (msk[n]) begin
        check("R1 valid", {31'b0, trc_valid}, 1);
        check("R7 busy", {31'b0, busy}, 1);
        check("R1 data", trc_data, pat(n));
        check("R1 port", {27'b0, trc_port}, 32'(n));
        pop1();
      end
      check("R2 empty after", {31'b0, busy}, 0);
    end

    // R4 status read at every port offset (not full)
    for (int n = 0; n < 32; n++) begin
      rd(12'(4 * n), r); check("R4 status room", r, 32'h1);
    end

    // R5/R6 fill, overflow, order, head hold
    wr(12'h400, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) wr(12'(4 * (k + 3)), pat(100 + k));
    rd(12'h07C, r); check("R4 status full", r, 32'h0);
    wr(12'h040, 32'hDEAD_BEEF);
    rd(12'h008, r); check("R5 overflow seen", r, 32'h2);
    rd(12'h008, r); check("R5 overflow cleared", r, 32'h0);
    rd(12'h404, r); check("R8 busy bit", r, 32'h8000_5501);
    repeat (3) @(negedge clk);
    check("R6 head hold", trc_data, pat(100));
    for (int k = 0; k < 4; k++) begin
      check("R6 order data", trc_data, pat(100 + k));
      check("R6 order port", {27'b0, trc_port}, 32'(k + 3));
      pop1();
    end
    check("R6 drained", {31'b0, trc_valid}, 0);
    check("R7 idle", {31'b0, busy}, 0);

    // R9 integration mode
    wr(12'h410, 32'h1);
    wr(12'h408, 32'h1);
    check("R9 driven valid", {31'b0, trc_valid}, 1);
    rd(12'h408, r); check("R12 drive readback", r, 32'h1);
    wr(12'h408, 32'h0);
    wr(12'h020, pat(7));
    check("R9 driven low", {31'b0, trc_valid}, 0);
    pop1(); pop1();
    check("R9 no drain", {31'b0, busy}, 1);
    wr(12'h410, 32'h0);
    check("R9 normal valid", {31'b0, trc_valid}, 1);
    check("R9 data kept", trc_data, pat(7));
    pop1();
    check("R9 drained", {31'b0, busy}, 0);

    // R10 live ready sample
    @(negedge clk); trc_ready = 1'b1; rd_en = 1'b1; addr = 12'h40C;
    @(negedge clk); rd_en = 1'b0; trc_ready = 1'b0;
    check("R10 ready high", rdata, 32'h1);
    rd(12'h40C, r); check("R10 ready low", r, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule